// File: doc/BRIEF.md
# Single-Bus Accumulator Processor

A small accumulator machine whose registers exchange data over one internal bus. The registers are the program counter, instruction register, accumulator, two general registers (R0, R1), a memory address register, a memory data register and a hidden operand holding register. In every cycle a microsequencer picks one bus source, through a multiplexer, and the set of registers that capture the bus on the next rising edge. The accumulator is the exception: it is always loaded from the ALU output.

Memory is reached only through the memory data register. When that register drives the bus, a read of the location in the address register starts. The returned word appears on the bus in the same cycle and is also kept in the data register. When the data register is loaded from the bus, a write of that word to the location in the address register is issued on the next cycle. The memory port has a combinational read and a write that takes effect on the clock edge.

Instruction word, 16 bits: opcode in bits 15:12, register field in bits 11:10, address or immediate in bits 9:0. Opcodes: 0 HALT, 1 LOAD, 2 STORE, 3 ADD, 4 SUB, 5 AND, 6 MOVTO (ACC to register), 7 MOVFROM (register to ACC), 8 JMP, 9 JZ, 10 LDI. Codes 11 to 15 do nothing.

Top module: `acc_bus_cpu`

## Requirements
- R1: An active-low asynchronous reset clears PC and ACC and returns the sequencer to its first fetch cycle. The first read strobe after release comes one cycle later, at address 0.
- R2: A fetch takes three cycles: PC to address register, instruction read into the instruction register, PC increment. Execution then takes 1 cycle for LDI, MOVTO, MOVFROM, JMP, JZ and codes 11 to 15; 2 cycles for LOAD and STORE; 3 cycles for ADD, SUB and AND. HALT raises `halted` after its three fetch cycles.
- R3: LOAD (opcode 1) puts the memory word at the address field into ACC. LDI (opcode 10) puts the zero-extended 10-bit immediate into ACC.
- R4: STORE (opcode 2) writes ACC to the address field, with a single write strobe whose data equals ACC.
- R5: ADD, SUB and AND (opcodes 3, 4, 5) replace ACC with ACC+M, ACC-M or ACC&M modulo 2^16, where M is the memory word at the address field.
- R6: MOVTO (opcode 6) copies ACC to R0 when the register field is 0 and to R1 when it is 1. With field 2 or 3 the value is discarded. MOVFROM (opcode 7) loads ACC from R0 (field 0) or R1 (field 1), and loads 0 for field 2 or 3.
- R7: JMP (opcode 8) continues at the address field. JZ (opcode 9) does the same only when the last value loaded into ACC was zero; otherwise execution falls through.
- R8: After HALT, `halted` stays high and neither strobe is asserted until reset.
- R9: Opcodes 11 to 15 leave ACC and the instruction order unchanged.
- R10: The read and write strobes are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | AW | Memory address (address register) |
| mem_wdata | output | DW | Write data (data register) |
| mem_rdata | input | DW | Read data, valid in the same cycle as the read strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe, write on the next rising edge |
| halted | output | 1 | High once HALT has executed |

## Verification
The arithmetic path runs a load/add/store, load/sub/store, load/and/store program over every ordered pair from a six-value set. The set holds 0, 1, the signed extremes, all ones and a mixed pattern, so carry wrap, borrow wrap and masking are each separated from a pass-through value. Further programs cover the remaining cases. JZ is run once taken and once not taken, which shows whether the zero flag follows the latest ACC load. Register moves cover all four field codes, which shows the two real registers apart from the discard and zero cases. A run of undefined codes is checked for its exact cycle count. The halted state is watched for stray strobes.

// File: rtl/acc_bus_cpu.sv
module acc_bus_cpu #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          halted
);
  localparam logic [3:0] OP_HALT = 4'd0, OP_LOAD = 4'd1, OP_STORE = 4'd2, OP_ADD = 4'd3,
                         OP_SUB = 4'd4, OP_AND = 4'd5, OP_MOVTO = 4'd6, OP_MOVFR = 4'd7,
                         OP_JMP = 4'd8, OP_JZ = 4'd9, OP_LDI = 4'd10;

  typedef enum logic [2:0] {F0, F1, F2, E0, E1, E2, HLT} st_t;
  typedef enum logic [2:0] {B_NONE, B_PC, B_MDR, B_ADR, B_ACC, B_REG} bsrc_t;
  typedef enum logic [1:0] {A_PASS, A_ADD, A_SUB, A_AND} aop_t;

  st_t st, nxt;
  bsrc_t src;
  aop_t aop;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] ir, acc, r0, r1, mdr, tmp, bus, alu, regv;
  logic zf, wr_pend;
  logic ld_mar, ld_ir, ld_acc, ld_tmp, ld_pc, ld_reg, ld_mdr, inc_pc;

  wire [3:0]    op  = ir[DW-1:DW-4];
  wire [1:0]    fld = ir[DW-5:DW-6];
  wire [AW-1:0] adr = ir[AW-1:0];

  always_comb begin
    src = B_NONE; aop = A_PASS; nxt = st;
    ld_mar = 1'b0; ld_ir = 1'b0; ld_acc = 1'b0; ld_tmp = 1'b0;
    ld_pc = 1'b0; ld_reg = 1'b0; ld_mdr = 1'b0; inc_pc = 1'b0;
    case (st)
      F0: begin src = B_PC; ld_mar = 1'b1; nxt = F1; end
      F1: begin src = B_MDR; ld_ir = 1'b1; nxt = F2; end
      F2: begin inc_pc = 1'b1; nxt = (op == OP_HALT) ? HLT : E0; end
      E0: begin
        nxt = F0;
        case (op)
          OP_LOAD, OP_STORE: begin src = B_ADR; ld_mar = 1'b1; nxt = E1; end
          OP_ADD, OP_SUB, OP_AND: begin src = B_ACC; ld_tmp = 1'b1; nxt = E1; end
          OP_MOVTO: begin src = B_ACC; ld_reg = 1'b1; end
          OP_MOVFR: begin src = B_REG; ld_acc = 1'b1; end
          OP_JMP:   begin src = B_ADR; ld_pc = 1'b1; end
          OP_JZ:    begin src = B_ADR; ld_pc = zf; end
          OP_LDI:   begin src = B_ADR; ld_acc = 1'b1; end
          default: ;
        endcase
      end
      E1: begin
        nxt = F0;
        case (op)
          OP_LOAD:  begin src = B_MDR; ld_acc = 1'b1; end
          OP_STORE: begin src = B_ACC; ld_mdr = 1'b1; end
          default:  begin src = B_ADR; ld_mar = 1'b1; nxt = E2; end
        endcase
      end
      E2: begin
        src = B_MDR; ld_acc = 1'b1; nxt = F0;
        aop = (op == OP_ADD) ? A_ADD : (op == OP_SUB) ? A_SUB : A_AND;
      end
      default: nxt = HLT;
    endcase
  end

  always_comb begin
    case (fld)
      2'd0: regv = r0;
      2'd1: regv = r1;
      default: regv = '0;
    endcase
    case (src)
      B_PC:    bus = {{(DW-AW){1'b0}}, pc};
      B_MDR:   bus = mem_rdata;
      B_ADR:   bus = {{(DW-AW){1'b0}}, adr};
      B_ACC:   bus = acc;
      B_REG:   bus = regv;
      default: bus = '0;
    endcase
    case (aop)
      A_ADD:   alu = tmp + bus;
      A_SUB:   alu = tmp - bus;
      A_AND:   alu = tmp & bus;
      default: alu = bus;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= F0; pc <= '0; acc <= '0; zf <= 1'b1; wr_pend <= 1'b0;
      ir <= '0; r0 <= '0; r1 <= '0; mar <= '0; mdr <= '0; tmp <= '0;
    end else begin
      st <= nxt;
      wr_pend <= ld_mdr;
      if (ld_mar) mar <= bus[AW-1:0];
      if (ld_ir) ir <= bus;
      if (ld_tmp) tmp <= bus;
      if (ld_pc) pc <= bus[AW-1:0];
      else if (inc_pc) pc <= pc + 1'b1;
      if (ld_acc) begin acc <= alu; zf <= (alu == '0); end
      if (ld_reg && fld == 2'd0) r0 <= bus;
      if (ld_reg && fld == 2'd1) r1 <= bus;
      if (src == B_MDR) mdr <= mem_rdata;
      else if (ld_mdr) mdr <= bus;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_rd    = (src == B_MDR);
  assign mem_wr    = wr_pend;
  assign halted    = (st == HLT);

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  a_r8_halt_quiet:  assert property (@(posedge clk) disable iff (!rst_n) halted |-> (!mem_rd && !mem_wr));
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted);
  a_r4_wdata_acc:   assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> mem_wdata == acc);
  a_r2_fetch_addr:  assert property (@(posedge clk) disable iff (!rst_n) (st == F1) |-> (mem_rd && mem_addr == pc));
  a_r7_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
                      (st == E0 && op == OP_JMP) |=> pc == $past(adr));
  a_r7_zero_flag:   assert property (@(posedge clk) disable iff (!rst_n) ld_acc |=> zf == (acc == '0));
endmodule

// File: tb/tb_acc_bus_cpu.sv
module tb_acc_bus_cpu;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic mem_rd, mem_wr, halted;
  logic [15:0] mem [0:1023];
  int checks = 0, fails = 0, gcyc = 0;

  acc_bus_cpu dut (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
                   .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .halted(halted));

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    gcyc++;
    if (gcyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog R8 actual=%0d expected<150000", gcyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input int op, input int f, input int a);
    return {op[3:0], f[1:0], a[9:0]};
  endfunction

  task automatic clear;
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
  endtask

  task automatic run(output int n, output bit first_ok);
    repeat (2) @(negedge clk);
    rst_n = 1'b1; n = 0; first_ok = 1'b0;
    while (1) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 1) first_ok = mem_rd && (mem_addr == 10'd0);
      if (halted) break;
      if (n > 2000) begin
        checks++; fails++;
        $display("FAIL run watchdog R8 actual=%0d expected=halted", n);
        break;
      end
    end
  endtask

  initial begin
    int n, strobes;
    bit f;
    int vals[6] = '{0, 1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

    clear();
    mem[0] = ins(2, 0, 400); mem[1] = ins(0, 0, 0); mem[400] = 16'hBEEF;
    @(negedge clk);
    chk("R1 rd in reset", mem_rd, 0);
    chk("R1 wr in reset", mem_wr, 0);
    chk("R1 halted in reset", halted, 0);
    run(n, f);
    chk("R1 first read at 0", f, 1);
    chk("R1 acc cleared", mem[400], 0);

    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++) begin
        clear();
        mem[0] = ins(1, 0, 500); mem[1] = ins(3, 0, 501); mem[2] = ins(2, 0, 510);
        mem[3] = ins(1, 0, 500); mem[4] = ins(4, 0, 501); mem[5] = ins(2, 0, 511);
        mem[6] = ins(1, 0, 500); mem[7] = ins(5, 0, 501); mem[8] = ins(2, 0, 512);
        mem[9] = ins(0, 0, 0);
        mem[500] = vals[i][15:0]; mem[501] = vals[j][15:0];
        run(n, f);
        chk("R5 add", mem[510], (vals[i] + vals[j]) & 16'hFFFF);
        chk("R5 sub", mem[511], (vals[i] - vals[j]) & 16'hFFFF);
        chk("R5 and", mem[512], vals[i] & vals[j]);
        if (i == 0 && j == 0) chk("R2 alu program cycles", n, 51);
      end

    clear();
    mem[0] = ins(1, 0, 600); mem[1] = ins(2, 0, 601); mem[2] = ins(10, 0, 10'h3A5);
    mem[3] = ins(2, 0, 602); mem[4] = ins(0, 0, 0); mem[600] = 16'hC3C3;
    run(n, f);
    chk("R3 load", mem[601], 16'hC3C3);
    chk("R3 ldi zero-extended", mem[602], 16'h03A5);
    chk("R4 store keeps source", mem[600], 16'hC3C3);

    clear();
    mem[0] = ins(10, 0, 0);  mem[1] = ins(9, 0, 4);  mem[2] = ins(10, 0, 7);
    mem[3] = ins(2, 0, 200); mem[4] = ins(10, 0, 3); mem[5] = ins(9, 0, 8);
    mem[6] = ins(2, 0, 201); mem[7] = ins(0, 0, 0);  mem[8] = ins(10, 0, 9);
    mem[9] = ins(2, 0, 201); mem[10] = ins(0, 0, 0); mem[200] = 16'hAAAA;
    run(n, f);
    chk("R7 jz taken skips store", mem[200], 16'hAAAA);
    chk("R7 jz not taken falls through", mem[201], 3);

    clear();
    mem[0] = ins(8, 0, 5); mem[1] = ins(10, 0, 1); mem[2] = ins(2, 0, 303);
    mem[3] = ins(0, 0, 0); mem[5] = ins(10, 0, 2); mem[6] = ins(2, 0, 303);
    mem[7] = ins(0, 0, 0);
    run(n, f);
    chk("R7 jmp target", mem[303], 2);

    clear();
    mem[0] = ins(10, 0, 11); mem[1] = ins(6, 0, 0); mem[2] = ins(10, 0, 22);
    mem[3] = ins(6, 1, 0);   mem[4] = ins(10, 0, 33); mem[5] = ins(6, 2, 0);
    mem[6] = ins(7, 0, 0);   mem[7] = ins(2, 0, 300); mem[8] = ins(7, 1, 0);
    mem[9] = ins(2, 0, 301); mem[10] = ins(7, 3, 0); mem[11] = ins(2, 0, 302);
    mem[12] = ins(0, 0, 0);  mem[302] = 16'h5555;
    run(n, f);
    chk("R6 R0 move", mem[300], 11);
    chk("R6 R1 move", mem[301], 22);
    chk("R6 field 3 reads zero", mem[302], 0);

    clear();
    mem[0] = ins(10, 0, 5);
    for (int k = 0; k < 5; k++) mem[1+k] = ins(11 + k, 0, 0);
    mem[6] = ins(2, 0, 302); mem[7] = ins(0, 0, 0);
    run(n, f);
    chk("R9 undefined codes keep acc", mem[302], 5);
    chk("R2 R9 cycle count", n, 32);
    strobes = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (mem_rd || mem_wr) strobes++;
    end
    chk("R8 no strobes after halt", strobes, 0);
    chk("R8 halted sticky", halted, 1);
    chk("R10 strobes exclusive", mem_rd && mem_wr, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule